// File: doc/BRIEF.md
# Adaptive Sampling Window Generator

This block builds a moving sampling window out of three neighbouring interpolated phase strobes (early, middle, late) and turns it into control pulses for a half-rate, two-capacitor differential sampler. The window does not sit at a fixed place in time. It opens on the rising edge of the early strobe and closes on the falling edge of the late strobe, so it always brackets the middle strobe. The middle strobe is the only edge allowed through as the sampling clock. A positive tracking enable qualifies the opening and a negative tracking enable qualifies the closing. The gated sampling pulse needs both enables and an open window.

All logic is synchronous to a fast system clock. Each strobe is treated as a level and compared with its value in the previous cycle, which yields rising and falling events. The window state machine has three states. WIN_IDLE goes to WIN_OPEN when a qualified early rise arrives. WIN_OPEN goes to WIN_TAKEN when the first qualified middle rise arrives, and that event emits the pulse. Both WIN_OPEN and WIN_TAKEN return to WIN_IDLE on a qualified late fall, or when the timeout expires.

A second state machine steers the two sampler halves. It has four states:
- PP_LOWER_HOLD: the lower half holds and drives the filter while the upper half samples.
- PP_GAP_TO_UPPER: an idle cycle in which neither half holds.
- PP_UPPER_HOLD: the mirror image of PP_LOWER_HOLD.
- PP_GAP_TO_LOWER: the idle cycle on the way back.

The machine leaves a hold state in the cycle after a sampling pulse. If the late strobe never arrives, a counter closes the window and raises a sticky error flag.

Top module: `sampwin_gen`

## Requirements
- R1: During and after reset, win, samp_pulse, smp_upper, smp_lower, hld_upper and tmo_err are 0, and hld_lower is 1.
- R2: A rising edge of ph_early seen in a cycle with trk_pos high, while the window is closed, drives win high after the next clock edge. With trk_pos low, or while the window is already open, the edge has no effect.
- R3: A falling edge of ph_late seen with trk_neg high closes an open window after the next clock edge. With trk_neg low, the window stays open. A close takes priority over a middle rise in the same cycle.
- R4: samp_pulse is a one-cycle pulse. It appears after the clock edge on which ph_mid rises while the window is open and both trk_pos and trk_neg are high. A middle rise while the window is closed produces nothing.
- R5: At most one samp_pulse is produced per window. Later middle rises in the same window are ignored.
- R6: A sampling pulse is routed to smp_upper while hld_lower is 1, and to smp_lower while hld_upper is 1, in the same cycle as samp_pulse.
- R7: In the cycle after a sampling pulse, the active hold drops. After exactly one cycle with both holds low, the other hold rises. hld_lower and hld_upper are never both high.
- R8: If a window is still open after TIMEOUT_CYC cycles, it is forced closed, so win stays high for exactly TIMEOUT_CYC cycles, and tmo_err goes high together with the close.
- R9: Once set, tmo_err stays high until reset, whatever windows follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ph_early | input | 1 | First selected phase strobe (opens the window) |
| ph_mid | input | 1 | Middle phase strobe (sampling edge) |
| ph_late | input | 1 | Last selected phase strobe (closes on fall) |
| trk_pos | input | 1 | Positive tracking enable |
| trk_neg | input | 1 | Negative tracking enable |
| win | output | 1 | Moving sampling window |
| samp_pulse | output | 1 | Gated sampling pulse |
| smp_upper | output | 1 | Sample strobe for the upper half |
| smp_lower | output | 1 | Sample strobe for the lower half |
| hld_lower | output | 1 | Lower half holds and drives the filter |
| hld_upper | output | 1 | Upper half holds and drives the filter |
| tmo_err | output | 1 | Sticky window-timeout flag |

## Verification
The bench builds the block with TIMEOUT_CYC set to 12 instead of the default 64. A stuck window therefore hits its forced close within a short directed sequence, and random strobe patterns also run into the timeout every now and then. That makes it possible to check the exact window length and the sticky error alongside normal closes. Random toggling of the three strobes and the two enables also places middle rises before, inside and after windows. It produces several middle rises in one window and closes that coincide with a middle rise, which exercises the one-pulse rule and the ping-pong swap over many alternations.

// File: rtl/sampwin_pkg.sv
package sampwin_pkg;

    localparam int NUM_PH   = 3;
    localparam int PH_EARLY = 0;
    localparam int PH_MID   = 1;
    localparam int PH_LATE  = 2;

    typedef enum logic [1:0] {
        WIN_IDLE,
        WIN_OPEN,
        WIN_TAKEN
    } win_state_t;

    typedef enum logic [1:0] {
        PP_LOWER_HOLD,
        PP_GAP_TO_UPPER,
        PP_UPPER_HOLD,
        PP_GAP_TO_LOWER
    } pp_state_t;

endpackage

// File: rtl/sampwin_edges.sv
module sampwin_edges #(
    parameter int NUM = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] ph,
    output logic [NUM-1:0] rise,
    output logic [NUM-1:0] fall
);

    logic [NUM-1:0] ph_d;

    for (genvar i = 0; i < NUM; i++) begin : g_edge
        // previous level of each strobe, cleared by reset
        always_ff @(posedge clk) begin
            if (!rst_n) ph_d[i] <= 1'b0;
            else        ph_d[i] <= ph[i];
        end

        assign rise[i] = ph[i] & ~ph_d[i];
        assign fall[i] = ~ph[i] & ph_d[i];
    end

endmodule

// File: rtl/sampwin_window.sv
module sampwin_window
    import sampwin_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_early,
    input  logic rise_mid,
    input  logic fall_late,
    input  logic trk_pos,
    input  logic trk_neg,
    output logic take,
    output logic win,
    output logic pulse,
    output logic err
);

    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_CYC - 1);

    win_state_t st, st_nxt;
    logic [CW-1:0] cnt;
    logic close_req, tmo_fire, open_req;

    assign open_req  = rise_early & trk_pos;
    assign close_req = fall_late & trk_neg;
    assign tmo_fire  = (st != WIN_IDLE) && !close_req && (cnt == CNT_LAST);
    assign take      = (st == WIN_OPEN) && !close_req && !tmo_fire
                       && rise_mid && trk_pos && trk_neg;

    always_comb begin
        st_nxt = st;
        unique case (st)
            WIN_IDLE:  if (open_req) st_nxt = WIN_OPEN;
            WIN_OPEN: begin
                if (close_req || tmo_fire) st_nxt = WIN_IDLE;
                else if (take)             st_nxt = WIN_TAKEN;
            end
            WIN_TAKEN: if (close_req || tmo_fire) st_nxt = WIN_IDLE;
            default:   st_nxt = WIN_IDLE;
        endcase
    end

    // state register and open-time counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= WIN_IDLE;
            cnt <= '0;
        end else begin
            st <= st_nxt;
            if (st == WIN_IDLE || st_nxt == WIN_IDLE) cnt <= '0;
            else                                      cnt <= cnt + 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win   <= 1'b0;
            pulse <= 1'b0;
            err   <= 1'b0;
        end else begin
            win   <= (st_nxt != WIN_IDLE);
            pulse <= take;
            if (tmo_fire) err <= 1'b1;
        end
    end

    assert_open_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win) |-> $past(rise_early && trk_pos));

    assert_pulse_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> win);

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(TIMEOUT_CYC));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

endmodule

// File: rtl/sampwin_pingpong.sv
module sampwin_pingpong
    import sampwin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic pulse_done,
    output logic smp_upper,
    output logic smp_lower,
    output logic hld_lower,
    output logic hld_upper
);

    pp_state_t st, st_nxt;

    always_comb begin
        st_nxt = st;
        unique case (st)
            PP_LOWER_HOLD:   if (pulse_done) st_nxt = PP_GAP_TO_UPPER;
            PP_GAP_TO_UPPER: st_nxt = PP_UPPER_HOLD;
            PP_UPPER_HOLD:   if (pulse_done) st_nxt = PP_GAP_TO_LOWER;
            PP_GAP_TO_LOWER: st_nxt = PP_LOWER_HOLD;
            default:         st_nxt = PP_LOWER_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= PP_LOWER_HOLD;
        else        st <= st_nxt;
    end

    // outputs: sample strobes registered, holds decoded from state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_upper <= 1'b0;
            smp_lower <= 1'b0;
        end else begin
            smp_upper <= take && (st == PP_LOWER_HOLD);
            smp_lower <= take && (st == PP_UPPER_HOLD);
        end
    end

    always_comb begin
        hld_lower = 1'b0;
        hld_upper = 1'b0;
        unique case (st)
            PP_LOWER_HOLD:   hld_lower = 1'b1;
            PP_UPPER_HOLD:   hld_upper = 1'b1;
            PP_GAP_TO_UPPER,
            PP_GAP_TO_LOWER: ;
            default:         ;
        endcase
    end

    assert_upper_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_upper |-> hld_lower);

    assert_lower_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_lower |-> hld_upper);

    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(hld_lower && hld_upper));

    assert_gap_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hld_upper) |-> $past(!hld_lower));

    assert_gap_lower_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hld_lower) |-> $past(!hld_upper));

endmodule

// File: rtl/sampwin_gen.sv
module sampwin_gen
    import sampwin_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ph_early,
    input  logic ph_mid,
    input  logic ph_late,
    input  logic trk_pos,
    input  logic trk_neg,
    output logic win,
    output logic samp_pulse,
    output logic smp_upper,
    output logic smp_lower,
    output logic hld_lower,
    output logic hld_upper,
    output logic tmo_err
);

    logic [NUM_PH-1:0] ph_vec, ph_rise, ph_fall;
    logic take;

    assign ph_vec[PH_EARLY] = ph_early;
    assign ph_vec[PH_MID]   = ph_mid;
    assign ph_vec[PH_LATE]  = ph_late;

    sampwin_edges #(.NUM(NUM_PH)) u_edges (
        .clk  (clk),
        .rst_n(rst_n),
        .ph   (ph_vec),
        .rise (ph_rise),
        .fall (ph_fall)
    );

    sampwin_window #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_early(ph_rise[PH_EARLY]),
        .rise_mid  (ph_rise[PH_MID]),
        .fall_late (ph_fall[PH_LATE]),
        .trk_pos   (trk_pos),
        .trk_neg   (trk_neg),
        .take      (take),
        .win       (win),
        .pulse     (samp_pulse),
        .err       (tmo_err)
    );

    sampwin_pingpong u_pingpong (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .pulse_done(samp_pulse),
        .smp_upper (smp_upper),
        .smp_lower (smp_lower),
        .hld_lower (hld_lower),
        .hld_upper (hld_upper)
    );

endmodule

// File: tb/tb_sampwin_gen.sv
module tb_sampwin_gen;

    localparam int TMO = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ph_early = 1'b0, ph_mid = 1'b0, ph_late = 1'b0;
    logic trk_pos = 1'b0, trk_neg = 1'b0;
    logic win, samp_pulse, smp_upper, smp_lower, hld_lower, hld_upper, tmo_err;

    always #10 clk = ~clk;

    sampwin_gen #(.TIMEOUT_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n),
        .ph_early(ph_early), .ph_mid(ph_mid), .ph_late(ph_late),
        .trk_pos(trk_pos), .trk_neg(trk_neg),
        .win(win), .samp_pulse(samp_pulse),
        .smp_upper(smp_upper), .smp_lower(smp_lower),
        .hld_lower(hld_lower), .hld_upper(hld_upper),
        .tmo_err(tmo_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    logic e_win = 0, e_pulse = 0, e_su = 0, e_sl = 0, e_hl = 1, e_hu = 0, e_err = 0;
    logic m_open = 0, m_taken = 0;
    int   m_cnt = 0, m_pp = 0;
    logic pe = 0, pm = 0, pl = 0;
    logic last_mid_rise = 0;
    int   win_pulses = 0;
    logic prev_win = 0;

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int pp_next(input int pp, input logic pulse_seen);
        case (pp)
            0:       return pulse_seen ? 1 : 0;
            1:       return 2;
            2:       return pulse_seen ? 3 : 2;
            default: return 0;
        endcase
    endfunction

    task automatic model(input logic e, input logic m, input logic l,
                         input logic tp, input logic tn);
        logic re, rm, fl, tk;
        int old_pp;
        re = e & ~pe; rm = m & ~pm; fl = ~l & pl;
        old_pp = m_pp;
        m_pp = pp_next(m_pp, e_pulse);
        tk = 0;
        if (!m_open) begin
            if (re && tp) begin m_open = 1; m_taken = 0; m_cnt = 0; end
        end else if (fl && tn) begin
            m_open = 0;
        end else if (m_cnt == TMO - 1) begin
            m_open = 0; e_err = 1;
        end else begin
            if (!m_taken && rm && tp && tn) begin tk = 1; m_taken = 1; end
            m_cnt++;
        end
        e_win = m_open; e_pulse = tk;
        e_su = tk && (old_pp == 0);
        e_sl = tk && (old_pp == 2);
        e_hl = (m_pp == 0); e_hu = (m_pp == 2);
        last_mid_rise = rm;
        pe = e; pm = m; pl = l;
    endtask

    // one cycle: compare at negedge, then drive and advance the model
    task automatic step(input logic e, input logic m, input logic l,
                        input logic tp, input logic tn);
        @(negedge clk);
        chk("R2/R3 win", win, e_win);
        chk("R4 samp_pulse", samp_pulse, e_pulse);
        chk("R6 smp_upper", smp_upper, e_su);
        chk("R6 smp_lower", smp_lower, e_sl);
        chk("R7 hld_lower", hld_lower, e_hl);
        chk("R7 hld_upper", hld_upper, e_hu);
        chk("R8/R9 tmo_err", tmo_err, e_err);
        if (samp_pulse) chk("R4 pulse follows mid rise", last_mid_rise, 1'b1);
        chk("R7 holds exclusive", hld_lower & hld_upper, 1'b0);
        if (win && samp_pulse) win_pulses++;
        if (prev_win && !win) begin
            chk("R5 one pulse per window", win_pulses > 1, 1'b0);
            win_pulses = 0;
        end
        prev_win = win;
        ph_early = e; ph_mid = m; ph_late = l; trk_pos = tp; trk_neg = tn;
        model(e, m, l, tp, tn);
    endtask

    initial begin
        int wcnt;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held
        chk("R1 win", win, 1'b0);
        chk("R1 hld_lower", hld_lower, 1'b1);
        chk("R1 hld_upper", hld_upper, 1'b0);
        chk("R1 tmo_err", tmo_err, 1'b0);
        rst_n = 1'b1;
        step(0, 0, 0, 1, 1);
        step(0, 0, 0, 1, 1);

        // R2: early rise with trk_pos low is ignored
        step(1, 0, 0, 0, 1);
        step(1, 0, 0, 1, 1);
        step(0, 0, 0, 1, 1);
        chk("R2 gated open", win, 1'b0);

        // normal window with a second middle rise and a blocked close
        step(1, 0, 0, 1, 1);
        step(1, 1, 0, 1, 1);
        step(1, 0, 1, 1, 1);
        chk("R4 pulse after mid", samp_pulse, 1'b1);
        chk("R6 upper sampled first", smp_upper, 1'b1);
        step(0, 1, 1, 1, 1);
        chk("R7 gap after pulse", hld_lower | hld_upper, 1'b0);
        step(0, 0, 0, 1, 0);
        chk("R7 upper holds", hld_upper, 1'b1);
        step(0, 0, 1, 1, 1);
        chk("R3 blocked close keeps window", win, 1'b1);
        chk("R5 second mid ignored", samp_pulse, 1'b0);
        step(0, 0, 0, 1, 1);
        step(0, 0, 0, 1, 1);
        chk("R3 close on late fall", win, 1'b0);

        // mid rise outside a window
        step(0, 1, 0, 1, 1);
        step(0, 0, 0, 1, 1);
        chk("R4 no pulse outside window", samp_pulse, 1'b0);

        // second window, pulse routed to lower half
        step(1, 0, 1, 1, 1);
        step(1, 1, 1, 1, 1);
        step(0, 1, 1, 1, 1);
        chk("R6 lower sampled second", smp_lower, 1'b1);
        step(0, 0, 0, 1, 1);
        step(0, 0, 0, 1, 1);
        step(0, 0, 0, 1, 1);

        // R8: window with no late fall times out
        chk("R8 err clear before", tmo_err, 1'b0);
        step(1, 0, 0, 1, 1);
        wcnt = 0;
        for (int i = 0; i < TMO + 4; i++) begin
            step(1, 0, 0, 1, 1);
            if (win) wcnt++;
        end
        chk("R8 window length", wcnt == TMO, 1'b1);
        chk("R8 err set", tmo_err, 1'b1);

        // R9: further windows keep the flag
        step(0, 0, 1, 1, 1);
        step(1, 1, 1, 1, 1);
        step(1, 1, 0, 1, 1);
        step(0, 0, 0, 1, 1);
        chk("R9 err sticky", tmo_err, 1'b1);

        // reset again, then random strobe patterns
        @(negedge clk);
        rst_n = 1'b0;
        ph_early = 0; ph_mid = 0; ph_late = 0;
        @(negedge clk);
        rst_n = 1'b1;
        e_win = 0; e_pulse = 0; e_su = 0; e_sl = 0; e_hl = 1; e_hu = 0; e_err = 0;
        m_open = 0; m_taken = 0; m_cnt = 0; m_pp = 0; pe = 0; pm = 0; pl = 0;
        last_mid_rise = 0; win_pulses = 0; prev_win = 0;
        chk("R1 err cleared by reset", tmo_err, 1'b0);
        for (int i = 0; i < 4000; i++) begin
            logic e, m, l, tp, tn;
            e  = ph_early ^ ($urandom_range(0, 3) == 0);
            m  = ph_mid   ^ ($urandom_range(0, 2) == 0);
            l  = ph_late  ^ ($urandom_range(0, 3) == 0);
            tp = ($urandom_range(0, 7) != 0);
            tn = ($urandom_range(0, 7) != 0);
            step(e, m, l, tp, tn);
        end
        step(0, 0, 0, 1, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired, actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule